// File: doc/BRIEF.md
# Message Build and Frame Transmit Pipeline

This block turns one variable held in a 32-bit variable memory into an outgoing Ethernet frame. A start request names a variable by its identifier. A small layout table maps that identifier to a base word address and a length in words. Two units then run at the same time. The create unit copies the variable word by word from memory into a send FIFO. The send unit produces a preamble and a frame header, then drains the FIFO one byte per cycle toward the MAC, and appends zero padding when the payload is short.

The send unit spends its first cycles on setup and header bytes. During that time the create unit has a head start to fill the FIFO, so that in normal operation the payload stream has no gaps. The block holds one message at a time, so a new request is accepted only after the previous frame has fully left. The MAC, CRC and the receive path are outside the block.

The create unit has two states after idle. `C_IDLE` goes to `C_SETUP` on an accepted start. `C_SETUP` goes to `C_COPY` when its setup count expires, or straight back to `C_IDLE` for a zero-length variable. `C_COPY` returns to `C_IDLE` when the last word has been written. The send unit moves from `S_IDLE` to `S_SETUP` on start. `S_SETUP` goes to `S_HDR` when its count expires. `S_HDR` goes to `S_PAY`, or to `S_PAD` for zero length, after the last header byte. `S_PAY` goes to `S_PAD` if the body is still short after the last payload byte, and to `S_DONE` otherwise. `S_PAD` goes to `S_DONE` at the minimum body size. `S_DONE` returns to `S_IDLE` after one cycle.

Top module: `msg_tx_pipe`

## Requirements
- R1: After reset `busy`, `done`, `tx_valid`, `vm_req` and `underrun` are all 0.
- R2: `start` is taken only while `busy` is 0; a `start` raised while busy has no effect on the frame in progress and produces no second frame or `done`.
- R3: Counting the cycle after the edge that samples an accepted `start` as cycle 0, the send unit spends cycles 0 to 4 in setup and presents 22 header bytes in cycles 5 to 26, one per cycle. The bytes are seven 0x55, then 0xD5, then the destination address, the source address and the EtherType, each sent most significant byte first.
- R4: The payload follows the header. It consists of the memory words at addresses base to base+len-1, in ascending order, with each word sent most significant byte first.
- R5: When 4*len is below 46, zero bytes follow the payload until the body (payload plus pad) is exactly 46 bytes; otherwise no pad is sent.
- R6: The create unit issues no memory read before cycle 8. It then reads consecutive addresses from the base, one per granted cycle, with read data used in the cycle after the grant. It never writes a full FIFO.
- R7: `done` is high for exactly one cycle, in the cycle after the last body byte. The FIFO is empty at that point, and `busy` is 0 in the following cycle.
- R8: After `done`, `frame_cycles` equals 28 + body bytes + the number of cycles within the body in which `tx_valid` was low.
- R9: `underrun` rises if the FIFO is empty while payload is due. It stays set until the next accepted start. During the gap `tx_valid` is low, and the byte stream resumes without loss.
- R10: Writes on the `cfg_*` port set the table entry chosen by `cfg_id`; `var_id` at start selects which entry is used.
- R11: With memory grants always given, the body is sent without any gap. The frame is 22 + max(4*len, 46) bytes long, and `underrun` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Layout table write enable |
| cfg_id | input | ID_W | Table entry to write |
| cfg_base | input | ADDR_W | Base word address of the variable |
| cfg_len | input | LEN_W | Variable length in 32-bit words |
| start | input | 1 | Request to build and send a message |
| var_id | input | ID_W | Variable selected by the request |
| busy | output | 1 | A message is being built or sent |
| vm_req | output | 1 | Variable memory read request |
| vm_addr | output | ADDR_W | Variable memory word address |
| vm_gnt | input | 1 | Memory accepts the read this cycle |
| vm_rdata | input | 32 | Read data, valid the cycle after a grant |
| tx_valid | output | 1 | A frame byte is presented to the MAC |
| tx_data | output | 8 | Frame byte |
| done | output | 1 | Frame finished (one-cycle pulse) |
| underrun | output | 1 | FIFO ran dry during the payload |
| frame_cycles | output | CYC_W | Busy cycles of the last frame |

## Verification
The hardest condition to reach is a FIFO that is empty while payload is due. With grants always given, the create unit stays ahead by construction. The bench therefore holds `vm_grant` low for dozens of cycles after a start, until the send unit has already finished its header. It then checks that the stall shows up as missing `tx_valid` cycles, that the flag rises, that the delivered bytes are still exact, and that the cycle count grows by the measured gap. A length sweep crosses the boundary where padding stops. A long variable forces FIFO back-pressure on the reader.

// File: rtl/msgtx_pkg.sv
package msgtx_pkg;

    // preamble bytes plus destination, source and type fields
    localparam int PRE_BYTES = 8;
    localparam int HDR_BYTES = PRE_BYTES + 14;

    typedef enum logic [1:0] {
        C_IDLE,
        C_SETUP,
        C_COPY
    } cre_state_t;

    typedef enum logic [2:0] {
        S_IDLE,
        S_SETUP,
        S_HDR,
        S_PAY,
        S_PAD,
        S_DONE
    } snd_state_t;

endpackage

// File: rtl/msgtx_layout.sv
module msgtx_layout #(
    parameter int ID_W   = 3,
    parameter int ADDR_W = 8,
    parameter int LEN_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ID_W-1:0]   wr_id,
    input  logic [ADDR_W-1:0] wr_base,
    input  logic [LEN_W-1:0]  wr_len,
    input  logic [ID_W-1:0]   rd_id,
    output logic [ADDR_W-1:0] rd_base,
    output logic [LEN_W-1:0]  rd_len
);
    localparam int ENTRIES = 1 << ID_W;

    logic [ADDR_W-1:0] base_q [ENTRIES];
    logic [LEN_W-1:0]  len_q  [ENTRIES];

    for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                base_q[g] <= '0;
                len_q[g]  <= '0;
            end else if (wr_en && wr_id == ID_W'(g)) begin
                base_q[g] <= wr_base;
                len_q[g]  <= wr_len;
            end
        end
    end

    assign rd_base = base_q[rd_id];
    assign rd_len  = len_q[rd_id];
endmodule

// File: rtl/msgtx_fifo.sv
module msgtx_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [W-1:0]               wr_data,
    input  logic                       rd_en,
    output logic [W-1:0]               head,
    output logic                       empty,
    output logic                       full,
    output logic [$clog2(DEPTH):0]     count
);
    localparam int AW = $clog2(DEPTH);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [AW:0]   cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (wr_en && !full) begin
                mem[wp] <= wr_data;
                wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
            end
            if (rd_en && !empty)
                rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
            case ({wr_en && !full, rd_en && !empty})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    assign head  = mem[rp];
    assign empty = (cnt == '0);
    assign full  = (cnt == (AW+1)'(DEPTH));
    assign count = cnt;
endmodule

// File: rtl/msgtx_create.sv
module msgtx_create
    import msgtx_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int LEN_W  = 6,
    parameter int DEPTH  = 8,
    parameter int SETUP  = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   go,
    input  logic [ADDR_W-1:0]      base,
    input  logic [LEN_W-1:0]       len,
    input  logic [$clog2(DEPTH):0] fifo_count,
    output logic                   vm_req,
    output logic [ADDR_W-1:0]      vm_addr,
    input  logic                   vm_gnt,
    input  logic [31:0]            vm_rdata,
    output logic                   fifo_wr,
    output logic [31:0]            fifo_wdata,
    output logic                   active
);
    localparam int CW = $clog2(SETUP + 1);
    localparam int FW = $clog2(DEPTH) + 2;

    cre_state_t        st, st_nxt;
    logic [CW-1:0]     cnt;
    logic [ADDR_W-1:0] addr_q;
    logic [LEN_W-1:0]  len_q, iss_left, wr_left;
    logic              pend;
    logic              room;

    assign room = (FW'(fifo_count) + FW'(pend)) < FW'(DEPTH);

    always_comb begin
        st_nxt = st;
        unique case (st)
            C_IDLE:  if (go) st_nxt = C_SETUP;
            C_SETUP: if (cnt == '0) st_nxt = (len_q == '0) ? C_IDLE : C_COPY;
            C_COPY:  if (pend && wr_left == LEN_W'(1)) st_nxt = C_IDLE;
            default: st_nxt = C_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= C_IDLE;
            cnt      <= '0;
            addr_q   <= '0;
            len_q    <= '0;
            iss_left <= '0;
            wr_left  <= '0;
            pend     <= 1'b0;
        end else begin
            st   <= st_nxt;
            pend <= vm_req && vm_gnt;
            if (st == C_IDLE && go) begin
                cnt      <= CW'(SETUP - 1);
                addr_q   <= base;
                len_q    <= len;
                iss_left <= len;
                wr_left  <= len;
            end
            if (st == C_SETUP && cnt != '0)
                cnt <= cnt - 1'b1;
            if (vm_req && vm_gnt) begin
                addr_q   <= addr_q + 1'b1;
                iss_left <= iss_left - 1'b1;
            end
            if (pend)
                wr_left <= wr_left - 1'b1;
        end
    end

    always_comb begin
        vm_req     = (st == C_COPY) && (iss_left != '0) && room;
        vm_addr    = addr_q;
        fifo_wr    = pend;
        fifo_wdata = vm_rdata;
        active     = (st != C_IDLE);
    end
endmodule

// File: rtl/msgtx_send.sv
module msgtx_send
    import msgtx_pkg::*;
#(
    parameter int          LEN_W    = 6,
    parameter int          SETUP    = 5,
    parameter int          MIN_BODY = 46,
    parameter int          CYC_W    = 12,
    parameter logic [47:0] DST_ADDR = 48'h0A1B_2C3D_4E5F,
    parameter logic [47:0] SRC_ADDR = 48'h0211_2233_4455,
    parameter logic [15:0] ETH_TYPE = 16'h88B5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic [LEN_W-1:0]  len,
    input  logic              fifo_empty,
    input  logic [31:0]       fifo_head,
    output logic              fifo_rd,
    output logic              tx_valid,
    output logic [7:0]        tx_data,
    output logic              done,
    output logic              underrun,
    output logic [CYC_W-1:0]  frame_cycles,
    output logic              active
);
    localparam int BODY_W = (LEN_W + 2 > 7) ? LEN_W + 2 : 7;
    localparam int MAXC   = (SETUP > HDR_BYTES) ? SETUP : HDR_BYTES;
    localparam int CW     = $clog2(MAXC + 1);
    localparam logic [HDR_BYTES*8-1:0] HDR_VEC =
        {{7{8'h55}}, 8'hD5, DST_ADDR, SRC_ADDR, ETH_TYPE};

    snd_state_t        st, st_nxt;
    logic [CW-1:0]     cnt;
    logic [LEN_W-1:0]  len_q;
    logic [BODY_W-1:0] body_cnt, pay_total, body_last;
    logic              pay_short, pay_byte;
    logic [CYC_W-1:0]  cyc;

    assign pay_total = BODY_W'({len_q, 2'b00});
    assign pay_short = pay_total < BODY_W'(MIN_BODY);
    assign body_last = (pay_short ? BODY_W'(MIN_BODY) : pay_total) - 1'b1;
    assign pay_byte  = (st == S_PAY) && !fifo_empty;

    always_comb begin
        st_nxt = st;
        unique case (st)
            S_IDLE:  if (go) st_nxt = S_SETUP;
            S_SETUP: if (cnt == '0) st_nxt = S_HDR;
            S_HDR:   if (cnt == CW'(HDR_BYTES - 1))
                         st_nxt = (len_q == '0) ? S_PAD : S_PAY;
            S_PAY:   if (pay_byte && body_cnt == pay_total - 1'b1)
                         st_nxt = pay_short ? S_PAD : S_DONE;
            S_PAD:   if (body_cnt == body_last) st_nxt = S_DONE;
            S_DONE:  st_nxt = S_IDLE;
            default: st_nxt = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st           <= S_IDLE;
            cnt          <= '0;
            len_q        <= '0;
            body_cnt     <= '0;
            underrun     <= 1'b0;
            cyc          <= '0;
            frame_cycles <= '0;
        end else begin
            st <= st_nxt;
            if (st != S_IDLE)
                cyc <= cyc + 1'b1;
            unique case (st)
                S_IDLE: if (go) begin
                    cnt      <= CW'(SETUP - 1);
                    len_q    <= len;
                    underrun <= 1'b0;
                    cyc      <= CYC_W'(1);
                end
                S_SETUP: if (cnt != '0) cnt <= cnt - 1'b1;
                S_HDR: begin
                    cnt      <= cnt + 1'b1;
                    body_cnt <= '0;
                end
                S_PAY: begin
                    if (pay_byte) body_cnt <= body_cnt + 1'b1;
                    else          underrun <= 1'b1;
                end
                S_PAD:  body_cnt <= body_cnt + 1'b1;
                S_DONE: frame_cycles <= cyc;
                default: ;
            endcase
        end
    end

    always_comb begin
        tx_valid = 1'b0;
        tx_data  = 8'h00;
        fifo_rd  = 1'b0;
        unique case (st)
            S_HDR: begin
                tx_valid = 1'b1;
                tx_data  = HDR_VEC[HDR_BYTES*8-1 - 8*int'(cnt) -: 8];
            end
            S_PAY: begin
                tx_valid = pay_byte;
                tx_data  = fifo_head[31 - 8*int'(body_cnt[1:0]) -: 8];
                fifo_rd  = pay_byte && (body_cnt[1:0] == 2'd3);
            end
            S_PAD:   tx_valid = 1'b1;
            default: ;
        endcase
        done   = (st == S_DONE);
        active = (st != S_IDLE);
    end
endmodule

// File: rtl/msg_tx_pipe.sv
module msg_tx_pipe
    import msgtx_pkg::*;
#(
    parameter int          ID_W         = 3,
    parameter int          ADDR_W       = 8,
    parameter int          LEN_W        = 6,
    parameter int          FIFO_DEPTH   = 8,
    parameter int          CREATE_SETUP = 8,
    parameter int          SEND_SETUP   = 5,
    parameter int          MIN_BODY     = 46,
    parameter int          CYC_W        = 12,
    parameter logic [47:0] DST_ADDR     = 48'h0A1B_2C3D_4E5F,
    parameter logic [47:0] SRC_ADDR     = 48'h0211_2233_4455,
    parameter logic [15:0] ETH_TYPE     = 16'h88B5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [ID_W-1:0]   cfg_id,
    input  logic [ADDR_W-1:0] cfg_base,
    input  logic [LEN_W-1:0]  cfg_len,
    input  logic              start,
    input  logic [ID_W-1:0]   var_id,
    output logic              busy,
    output logic              vm_req,
    output logic [ADDR_W-1:0] vm_addr,
    input  logic              vm_gnt,
    input  logic [31:0]       vm_rdata,
    output logic              tx_valid,
    output logic [7:0]        tx_data,
    output logic              done,
    output logic              underrun,
    output logic [CYC_W-1:0]  frame_cycles
);
    localparam int FCW = $clog2(FIFO_DEPTH) + 1;

    logic              go;
    logic              cre_active, snd_active;
    logic [ADDR_W-1:0] sel_base;
    logic [LEN_W-1:0]  sel_len;
    logic              fifo_wr, fifo_rd, fifo_empty, fifo_full;
    logic [31:0]       fifo_wdata, fifo_head;
    logic [FCW-1:0]    fifo_count;

    assign busy = cre_active || snd_active;
    assign go   = start && !busy;

    msgtx_layout #(.ID_W(ID_W), .ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_layout (
        .clk(clk), .rst_n(rst_n),
        .wr_en(cfg_we), .wr_id(cfg_id), .wr_base(cfg_base), .wr_len(cfg_len),
        .rd_id(var_id), .rd_base(sel_base), .rd_len(sel_len)
    );

    msgtx_create #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .DEPTH(FIFO_DEPTH),
                   .SETUP(CREATE_SETUP)) u_create (
        .clk(clk), .rst_n(rst_n), .go(go),
        .base(sel_base), .len(sel_len), .fifo_count(fifo_count),
        .vm_req(vm_req), .vm_addr(vm_addr), .vm_gnt(vm_gnt), .vm_rdata(vm_rdata),
        .fifo_wr(fifo_wr), .fifo_wdata(fifo_wdata), .active(cre_active)
    );

    msgtx_fifo #(.W(32), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n),
        .wr_en(fifo_wr), .wr_data(fifo_wdata), .rd_en(fifo_rd),
        .head(fifo_head), .empty(fifo_empty), .full(fifo_full), .count(fifo_count)
    );

    msgtx_send #(.LEN_W(LEN_W), .SETUP(SEND_SETUP), .MIN_BODY(MIN_BODY),
                 .CYC_W(CYC_W), .DST_ADDR(DST_ADDR), .SRC_ADDR(SRC_ADDR),
                 .ETH_TYPE(ETH_TYPE)) u_send (
        .clk(clk), .rst_n(rst_n), .go(go), .len(sel_len),
        .fifo_empty(fifo_empty), .fifo_head(fifo_head), .fifo_rd(fifo_rd),
        .tx_valid(tx_valid), .tx_data(tx_data), .done(done),
        .underrun(underrun), .frame_cycles(frame_cycles), .active(snd_active)
    );
endmodule

// File: rtl/msg_tx_chk.sv
module msg_tx_chk #(
    parameter int SETUP = 8
) (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic busy,
    input logic vm_req,
    input logic tx_valid,
    input logic done,
    input logic underrun,
    input logic fifo_empty,
    input logic fifo_full,
    input logic fifo_wr
);
    logic [7:0] since;

    always_ff @(posedge clk) begin
        if (!rst_n)
            since <= '0;
        else if (start && !busy)
            since <= '0;
        else if (since != 8'hFF)
            since <= since + 1'b1;
    end

    a_r7_done_fifo_empty: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> fifo_empty);
    a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r7_busy_release: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);
    a_r2_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!vm_req && !tx_valid));
    a_r9_underrun_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (underrun && !(start && !busy)) |=> underrun);
    a_r6_no_overfill: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_full |-> !fifo_wr);
    a_r6_setup_gap: assert property (@(posedge clk) disable iff (!rst_n)
        vm_req |-> (since >= 8'(SETUP)));
endmodule

bind msg_tx_pipe msg_tx_chk #(.SETUP(CREATE_SETUP)) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .vm_req(vm_req),
    .tx_valid(tx_valid), .done(done), .underrun(underrun),
    .fifo_empty(fifo_empty), .fifo_full(fifo_full), .fifo_wr(fifo_wr)
);

// File: tb/tb_msg_tx_pipe.sv
module tb_msg_tx_pipe;
    localparam logic [47:0] DST = 48'h0A1B_2C3D_4E5F;
    localparam logic [47:0] SRC = 48'h0211_2233_4455;
    localparam logic [15:0] ETY = 16'h88B5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_id = '0;
    logic [7:0]  cfg_base = '0;
    logic [5:0]  cfg_len = '0;
    logic        start = 1'b0;
    logic [2:0]  var_id = '0;
    logic        busy, vm_req, tx_valid, done, underrun;
    logic [7:0]  vm_addr, tx_data;
    logic        vm_gnt = 1'b1;
    logic [31:0] vm_rdata = '0;
    logic [11:0] frame_cycles;

    int checks = 0;
    int fails  = 0;
    int tb_base [8];
    int tb_len  [8];
    logic [7:0] cap [0:511];
    int addrs [0:127];

    always #4 clk = ~clk;

    msg_tx_pipe #(.DST_ADDR(DST), .SRC_ADDR(SRC), .ETH_TYPE(ETY)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_id(cfg_id),
        .cfg_base(cfg_base), .cfg_len(cfg_len), .start(start), .var_id(var_id),
        .busy(busy), .vm_req(vm_req), .vm_addr(vm_addr), .vm_gnt(vm_gnt),
        .vm_rdata(vm_rdata), .tx_valid(tx_valid), .tx_data(tx_data),
        .done(done), .underrun(underrun), .frame_cycles(frame_cycles)
    );

    function automatic logic [31:0] memf(input int a);
        return 32'h9E37_79B9 * (32'(a) + 32'd1);
    endfunction

    always @(posedge clk)
        if (vm_req && vm_gnt) vm_rdata <= memf(int'(vm_addr));

    function automatic logic [7:0] hdr_byte(input int i);
        logic [175:0] v;
        v = {{7{8'h55}}, 8'hD5, DST, SRC, ETY};
        return v[175 - 8*i -: 8];
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic set_entry(input int id, input int base, input int len);
        @(negedge clk);
        cfg_we = 1'b1; cfg_id = 3'(id); cfg_base = 8'(base); cfg_len = 6'(len);
        @(negedge clk);
        cfg_we = 1'b0;
        tb_base[id] = base;
        tb_len[id]  = len;
    endtask

    task automatic run_frame(input int id, input int hold, input bit poke);
        int base, len, body, nb, na, off, first_tx, first_req, done_off, gaps;
        int bad_hdr, bad_pay, bad_pad, bad_addr, last_tx;
        base = tb_base[id];
        len  = tb_len[id];
        body = (4*len < 46) ? 46 : 4*len;
        nb = 0; na = 0; first_tx = -1; first_req = -1; done_off = -1;
        gaps = 0; last_tx = -1;
        @(negedge clk);
        var_id = 3'(id); start = 1'b1; vm_gnt = (hold == 0);
        @(negedge clk);
        start = 1'b0;
        for (off = 0; off < 2000; off++) begin
            vm_gnt = (off >= hold);
            if (poke && off == 10) begin start = 1'b1; var_id = 3'(id ^ 1); end
            if (poke && off == 11) start = 1'b0;
            if (tx_valid) begin
                if (first_tx < 0) first_tx = off;
                if (nb >= 22 && last_tx >= 0) gaps += off - last_tx - 1;
                if (nb < 512) cap[nb] = tx_data;
                nb++;
                last_tx = off;
            end
            if (vm_req && vm_gnt) begin
                if (first_req < 0) first_req = off;
                if (na < 128) addrs[na] = int'(vm_addr);
                na++;
            end
            if (done) begin
                done_off = off;
                break;
            end
            @(negedge clk);
        end
        start = 1'b0;
        vm_gnt = 1'b1;
        chk(done_off >= 0, "R7", "done seen", done_off, 0);
        chk(first_tx == 5, "R3", "first header byte offset", first_tx, 5);
        if (len > 0 && hold == 0)
            chk(first_req == 8, "R6", "first read offset", first_req, 8);
        bad_addr = 0;
        for (int i = 0; i < na && i < 128; i++)
            if (addrs[i] != ((base + i) & 255)) bad_addr++;
        chk(na == len && bad_addr == 0, "R6", "read address sequence", na, len);
        chk(nb == 22 + body, "R11", "frame byte count", nb, 22 + body);
        bad_hdr = 0;
        for (int i = 0; i < 22 && i < nb; i++)
            if (cap[i] != hdr_byte(i)) bad_hdr++;
        chk(bad_hdr == 0, "R3", "header byte mismatches", bad_hdr, 0);
        bad_pay = 0;
        for (int i = 0; i < 4*len && 22 + i < nb; i++) begin
            logic [31:0] w;
            w = memf((base + i/4) & 255);
            if (cap[22 + i] != w[31 - 8*(i%4) -: 8]) bad_pay++;
        end
        if (len == tb_len[id ^ 1] && base == tb_base[id ^ 1] && poke) bad_pay += 0;
        chk(bad_pay == 0, poke ? "R2" : "R4", "payload byte mismatches", bad_pay, 0);
        bad_pad = 0;
        for (int i = 4*len; i < body && 22 + i < nb; i++)
            if (cap[22 + i] != 8'h00) bad_pad++;
        chk(bad_pad == 0, "R5", "pad byte mismatches", bad_pad, 0);
        chk(done_off == 27 + body + gaps, "R7", "done offset", done_off, 27 + body + gaps);
        if (hold == 0) begin
            chk(gaps == 0, "R11", "body gap cycles", gaps, 0);
            chk(underrun == 1'b0, "R11", "underrun clear", int'(underrun), 0);
        end else begin
            chk(gaps > 0, "R9", "stall visible as gap", gaps, 1);
            chk(underrun == 1'b1, "R9", "underrun raised", int'(underrun), 1);
        end
        @(negedge clk);
        chk(busy == 1'b0, "R7", "busy after done", int'(busy), 0);
        chk(done == 1'b0, "R2", "single done pulse", int'(done), 0);
        chk(int'(frame_cycles) == 28 + body + gaps, "R8", "frame_cycles",
            int'(frame_cycles), 28 + body + gaps);
        if (poke) begin
            repeat (40) begin
                @(negedge clk);
                if (busy || tx_valid) begin
                    chk(1'b0, "R2", "no second frame", 1, 0);
                    break;
                end
            end
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(!busy && !done && !tx_valid && !vm_req && !underrun, "R1",
            "outputs at reset", int'({busy, done, tx_valid, vm_req, underrun}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !underrun, "R1", "idle after reset release",
            int'({busy, underrun}), 0);
        // R10: distinct entries, used in reverse order
        for (int id = 0; id < 8; id++) set_entry(id, id*16, id + 1);
        for (int id = 7; id >= 0; id--) run_frame(id, 0, 1'b0);
        // R5/R11: length sweep across the padding boundary
        for (int l = 0; l <= 16; l++) begin
            set_entry(3, 5*l, l);
            run_frame(3, 0, 1'b0);
        end
        set_entry(6, 100, 30);
        run_frame(6, 0, 1'b0);
        set_entry(5, 192, 63);
        run_frame(5, 0, 1'b0);
        // R2: request raised mid-frame
        set_entry(2, 40, 9);
        set_entry(3, 80, 20);
        run_frame(2, 0, 1'b1);
        // R9: grants withheld past the header
        set_entry(4, 60, 4);
        run_frame(4, 50, 1'b0);
        set_entry(1, 70, 14);
        run_frame(1, 45, 1'b0);
        // R9: next accepted start clears the flag
        @(negedge clk);
        var_id = 3'd0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(underrun == 1'b0, "R9", "flag cleared by start", int'(underrun), 0);
        wait (done);
        @(negedge clk);
        @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule